// File: doc/BRIEF.md
# Shadow Write Mirroring Unit

This block sits on the write path of a memory system with a 24-bit physical address space. Every CPU write that reaches it is first issued as a primary write to its own physical address. A second write follows in the next cycle. That second write goes to a fixed 128 KB video shadow window when the target is marked for shadowing. Otherwise it repeats the primary address, which has no effect on memory.

Two 128-entry bitmaps control shadowing. The source map has one bit for each 128 KB bank of the physical space. The destination map has one bit for each 1 KB page inside a 128 KB window. A write is mirrored only when both of its bits are set. The mirror address keeps the low 17 address bits and puts the shadow base above them. Writes into read-only regions are discarded. A simple word-wide configuration port loads the bitmaps.

Top module: `shadow_mirror`

## Requirements
- R1: After reset, no write strobe is active, `busy` is 0, and both bitmaps are all zero. A write issued before any configuration therefore has `sec_mirror`=0 and `sec_addr` equal to its own address.
- R2: A request with `wr_writable`=0 is discarded. No primary strobe, no secondary strobe and no `busy` follow it.
- R3: A writable request accepted on a rising edge gives `pri_we`=1 during the next cycle, with `pri_addr`/`pri_data` equal to the request's address and data.
- R4: `sec_we` is 1 in the cycle right after each `pri_we` cycle, and `sec_data` equals the primary data.
- R5: `busy` is 1 in the primary cycle and only there. A request presented while `busy`=1 is ignored.
- R6: The bank index is address bits [23:17] and the page index is bits [16:10]. When both indexed bits are set, `sec_mirror`=1 and `sec_addr` = {SHADOW_BASE[23:17], addr[16:0]} (default base 0xE00000).
- R7: When either indexed bit is clear, `sec_mirror`=0 and `sec_addr` equals the primary address.
- R8: A configuration write with `cfg_sel`=0 loads the bank map and with `cfg_sel`=1 loads the page map. `cfg_word`=w replaces map bits [32w+31:32w]. The new value applies to requests accepted on later edges. A request on the same edge as the load sees the old map.
- R9: A request presented during the secondary cycle is accepted, and its primary write follows without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | Write request |
| wr_writable | input | 1 | Target region is writable RAM |
| wr_addr | input | 24 | Physical write address |
| wr_data | input | 8 | Write data |
| cfg_we | input | 1 | Bitmap word load strobe |
| cfg_sel | input | 1 | 0 = bank map, 1 = page map |
| cfg_word | input | 2 | Word index within the selected map |
| cfg_data | input | 32 | Word value |
| busy | output | 1 | Primary cycle in progress; requests ignored |
| pri_we | output | 1 | Primary write strobe |
| pri_addr | output | 24 | Primary write address |
| pri_data | output | 8 | Primary write data |
| sec_we | output | 1 | Secondary write strobe |
| sec_addr | output | 24 | Secondary write address |
| sec_data | output | 8 | Secondary write data |
| sec_mirror | output | 1 | Secondary write targets the shadow window |

## Verification
The embedded assertions check the rules of the two-write sequence on every cycle: the secondary write always follows the primary, busy lasts one cycle, data carries over, read-only requests raise no strobe, mirrored addresses fall in the shadow window, and unmirrored addresses repeat the primary. They also check that configuration words are loaded. Only the bench scenarios can show that the correct bank and page bits are chosen for a given address, that the 17-bit wrap gives the expected window offset, and that a map update on the same edge as a request does not affect that request. The same applies to dropping a request made while busy.

// File: rtl/shm_pkg.sv
package shm_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_PRI  = 2'd1,
        SQ_SEC  = 2'd2
    } seq_state_t;

endpackage

// File: rtl/shm_map_store.sv
module shm_map_store #(
    parameter int ENTRIES = 128,
    parameter int CFG_W   = 32,
    localparam int WORDS   = ENTRIES / CFG_W,
    localparam int WORD_IW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [WORD_IW-1:0] cfg_word,
    input  logic [CFG_W-1:0]   cfg_data,
    output logic [ENTRIES-1:0] bank_map,
    output logic [ENTRIES-1:0] page_map
);

    typedef struct packed {
        logic [ENTRIES-1:0] bank;
        logic [ENTRIES-1:0] page;
    } map_t;

    map_t map_d, map_q;
    logic [WORDS-1:0] word_hit;

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        assign word_hit[g] = cfg_we && (cfg_word == WORD_IW'(g));
    end

    always_comb begin
        map_d = map_q;
        for (int w = 0; w < WORDS; w++) begin
            if (word_hit[w]) begin
                if (cfg_sel) map_d.page[w*CFG_W +: CFG_W] = cfg_data;
                else         map_d.bank[w*CFG_W +: CFG_W] = cfg_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) map_q <= '0;
        else        map_q <= map_d;
    end

    assign bank_map = map_q.bank;
    assign page_map = map_q.page;

    // R8: a loaded word shows up in the selected map on the next cycle
    p_cfg_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_sel) |=>
        ((bank_map >> ($past(cfg_word) * CFG_W)) & {{(ENTRIES-CFG_W){1'b0}}, {CFG_W{1'b1}}})
            == {{(ENTRIES-CFG_W){1'b0}}, $past(cfg_data)});
    p_cfg_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel) |=>
        ((page_map >> ($past(cfg_word) * CFG_W)) & {{(ENTRIES-CFG_W){1'b0}}, {CFG_W{1'b1}}})
            == {{(ENTRIES-CFG_W){1'b0}}, $past(cfg_data)});

endmodule

// File: rtl/shm_decide.sv
module shm_decide #(
    parameter int          ADDR_W      = 24,
    parameter int          IDX_W       = 7,
    parameter int          PAGE_LSB    = 10,
    parameter logic [23:0] SHADOW_BASE = 24'hE0_0000,
    localparam int ENTRIES  = 1 << IDX_W,
    localparam int BANK_LSB = ADDR_W - IDX_W
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [ENTRIES-1:0] bank_map,
    input  logic [ENTRIES-1:0] page_map,
    output logic               hit,
    output logic [ADDR_W-1:0]  mirror_addr
);

    localparam logic [IDX_W-1:0] BASE_HI = SHADOW_BASE[ADDR_W-1:BANK_LSB];

    logic [IDX_W-1:0] bank_idx;
    logic [IDX_W-1:0] page_idx;

    always_comb begin
        bank_idx    = addr[BANK_LSB +: IDX_W];
        page_idx    = addr[PAGE_LSB +: IDX_W];
        hit         = bank_map[bank_idx] & page_map[page_idx];
        mirror_addr = hit ? {BASE_HI, addr[BANK_LSB-1:0]} : addr;
    end

endmodule

// File: rtl/shm_sequencer.sv
module shm_sequencer
    import shm_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              writable,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              hit,
    input  logic [ADDR_W-1:0] mirror_addr,
    output logic              busy,
    output logic              pri_we,
    output logic [ADDR_W-1:0] pri_addr,
    output logic [DATA_W-1:0] pri_data,
    output logic              sec_we,
    output logic [ADDR_W-1:0] sec_addr,
    output logic [DATA_W-1:0] sec_data,
    output logic              sec_mirror
);

    typedef struct packed {
        seq_state_t        st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [ADDR_W-1:0] maddr;
        logic              hit;
    } seq_t;

    seq_t s_d, s_q;
    logic accept;

    always_comb begin
        s_d    = s_q;
        accept = req && writable && (s_q.st != SQ_PRI);
        case (s_q.st)
            SQ_PRI:  s_d.st = SQ_SEC;
            default: s_d.st = SQ_IDLE;
        endcase
        if (accept) begin
            s_d.st    = SQ_PRI;
            s_d.addr  = addr;
            s_d.data  = data;
            s_d.maddr = mirror_addr;
            s_d.hit   = hit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: SQ_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign busy       = (s_q.st == SQ_PRI);
    assign pri_we     = (s_q.st == SQ_PRI);
    assign pri_addr   = s_q.addr;
    assign pri_data   = s_q.data;
    assign sec_we     = (s_q.st == SQ_SEC);
    assign sec_addr   = s_q.maddr;
    assign sec_data   = s_q.data;
    assign sec_mirror = s_q.hit;

    // R4: secondary strobe always follows a primary strobe
    p_sec_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pri_we |=> sec_we);
    p_sec_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sec_we |-> ($past(pri_we) && sec_data == $past(pri_data)));
    // R5: busy never lasts two cycles
    p_busy_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
    // R2: read-only requests raise no strobe
    p_drop_readonly_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !writable && !busy) |=> !pri_we);
    // R7: an unmirrored second write repeats the primary address
    p_unmirrored_same_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_we && !sec_mirror) |-> (sec_addr == $past(pri_addr)));
    // R6: a mirrored second write keeps the low bits of the primary address
    p_mirror_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_we && sec_mirror) |-> (sec_addr[ADDR_W-8:0] == $past(pri_addr[ADDR_W-8:0])));

endmodule

// File: rtl/shadow_mirror.sv
module shadow_mirror #(
    parameter int          ADDR_W      = 24,
    parameter int          DATA_W      = 8,
    parameter int          IDX_W       = 7,
    parameter int          PAGE_LSB    = 10,
    parameter int          CFG_W       = 32,
    parameter logic [23:0] SHADOW_BASE = 24'hE0_0000,
    localparam int ENTRIES  = 1 << IDX_W,
    localparam int BANK_LSB = ADDR_W - IDX_W,
    localparam int WORDS    = ENTRIES / CFG_W,
    localparam int WORD_IW  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_req,
    input  logic               wr_writable,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [WORD_IW-1:0] cfg_word,
    input  logic [CFG_W-1:0]   cfg_data,
    output logic               busy,
    output logic               pri_we,
    output logic [ADDR_W-1:0]  pri_addr,
    output logic [DATA_W-1:0]  pri_data,
    output logic               sec_we,
    output logic [ADDR_W-1:0]  sec_addr,
    output logic [DATA_W-1:0]  sec_data,
    output logic               sec_mirror
);

    logic [ENTRIES-1:0] bank_map;
    logic [ENTRIES-1:0] page_map;
    logic               hit;
    logic [ADDR_W-1:0]  mirror_addr;

    shm_map_store #(.ENTRIES(ENTRIES), .CFG_W(CFG_W)) u_maps (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_word(cfg_word), .cfg_data(cfg_data),
        .bank_map(bank_map), .page_map(page_map)
    );

    shm_decide #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .PAGE_LSB(PAGE_LSB),
                 .SHADOW_BASE(SHADOW_BASE)) u_decide (
        .addr(wr_addr), .bank_map(bank_map), .page_map(page_map),
        .hit(hit), .mirror_addr(mirror_addr)
    );

    shm_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req(wr_req), .writable(wr_writable),
        .addr(wr_addr), .data(wr_data), .hit(hit), .mirror_addr(mirror_addr),
        .busy(busy), .pri_we(pri_we), .pri_addr(pri_addr), .pri_data(pri_data),
        .sec_we(sec_we), .sec_addr(sec_addr), .sec_data(sec_data),
        .sec_mirror(sec_mirror)
    );

    // R6: a mirrored write lands inside the shadow window
    p_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_we && sec_mirror) |-> (sec_addr[ADDR_W-1:BANK_LSB] == SHADOW_BASE[ADDR_W-1:BANK_LSB]));

endmodule

// File: tb/shadow_mirror_test.sv
`timescale 1ns/1ps
module shadow_mirror_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_req = 1'b0, wr_writable = 1'b0;
    logic [23:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [1:0]  cfg_word = '0;
    logic [31:0] cfg_data = '0;
    logic        busy, pri_we, sec_we, sec_mirror;
    logic [23:0] pri_addr, sec_addr;
    logic [7:0]  pri_data, sec_data;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    shadow_mirror uut (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_writable(wr_writable),
        .wr_addr(wr_addr), .wr_data(wr_data), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_word(cfg_word), .cfg_data(cfg_data), .busy(busy), .pri_we(pri_we),
        .pri_addr(pri_addr), .pri_data(pri_data), .sec_we(sec_we),
        .sec_addr(sec_addr), .sec_data(sec_data), .sec_mirror(sec_mirror)
    );

    typedef struct packed {
        logic [23:0] a;
        logic        w;
        logic        h;
    } vec_t;

    // maps: banks 0,1,64; pages 1, 8..15, 65
    localparam vec_t VT [10] = '{
        '{24'h000400, 1'b1, 1'b1},
        '{24'h002000, 1'b1, 1'b1},
        '{24'h001000, 1'b1, 1'b0},
        '{24'h010400, 1'b1, 1'b1},
        '{24'h020400, 1'b1, 1'b1},
        '{24'h040400, 1'b1, 1'b0},
        '{24'h800400, 1'b1, 1'b1},
        '{24'h002400, 1'b0, 1'b0},
        '{24'h03FFFF, 1'b1, 1'b0},
        '{24'hFFFFFF, 1'b1, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_sec(input logic [23:0] a, input logic h);
        return h ? {7'h70, a[16:0]} : a;
    endfunction

    task automatic cfg(input logic sel, input logic [1:0] w, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_word = w; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_wr(input logic [23:0] a, input logic w, input logic h, input logic [7:0] d);
        @(negedge clk);
        wr_req = 1'b1; wr_writable = w; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_req = 1'b0;
        if (w) begin
            chk(pri_we && busy, "R3/R5 primary strobe+busy", {30'd0, pri_we, busy}, 32'd3);
            chk(pri_addr == a && pri_data == d, "R3 primary addr/data", {pri_data, pri_addr}, {d, a});
        end else begin
            chk(!pri_we && !busy, "R2 read-only dropped", {30'd0, pri_we, busy}, 32'd0);
        end
        @(negedge clk);
        if (w) begin
            chk(sec_we && !busy && sec_data == d, "R4 secondary follows", {23'd0, sec_we, sec_data}, {23'd0, 1'b1, d});
            chk(sec_addr == exp_sec(a, h), h ? "R6 mirror address" : "R7 same address", {8'd0, sec_addr}, {8'd0, exp_sec(a, h)});
            chk(sec_mirror == h, "R6/R7 mirror flag", {31'd0, sec_mirror}, {31'd0, h});
        end else begin
            chk(!sec_we, "R2 no secondary", {31'd0, sec_we}, 32'd0);
        end
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=%0d expected<20000", cyc);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!pri_we && !sec_we && !busy, "R1 reset idle", {29'd0, pri_we, sec_we, busy}, 32'd0);
        rst_n = 1'b1;
        // R1: maps zero after reset
        run_wr(24'h000400, 1'b1, 1'b0, 8'h11);

        cfg(1'b0, 2'd0, 32'h0000_0003);
        cfg(1'b0, 2'd2, 32'h0000_0001);
        cfg(1'b1, 2'd0, 32'h0000_FF02);
        cfg(1'b1, 2'd2, 32'h0000_0002);

        for (int i = 0; i < 10; i++) begin
            run_wr(VT[i].a, VT[i].w, VT[i].h, 8'(8'h40 + i));
        end

        // R5: request while busy is ignored
        @(negedge clk);
        wr_req = 1'b1; wr_writable = 1'b1; wr_addr = 24'h000400; wr_data = 8'hA1;
        @(negedge clk);
        wr_addr = 24'h123456; wr_data = 8'hB2;
        @(negedge clk);
        wr_req = 1'b0;
        chk(sec_we && sec_addr == 24'hE00400, "R5 first write completes", {8'd0, sec_addr}, 32'hE00400);
        @(negedge clk);
        chk(!pri_we && !sec_we, "R5 busy request ignored", {30'd0, pri_we, sec_we}, 32'd0);

        // R9: request in the secondary cycle accepted without gap
        @(negedge clk);
        wr_req = 1'b1; wr_addr = 24'h002000; wr_data = 8'hC3;
        @(negedge clk);
        wr_req = 1'b0;
        @(negedge clk);
        wr_req = 1'b1; wr_addr = 24'h001000; wr_data = 8'hD4;
        @(negedge clk);
        wr_req = 1'b0;
        chk(pri_we && pri_addr == 24'h001000 && pri_data == 8'hD4, "R9 back-to-back primary", {8'd0, pri_addr}, 32'h001000);
        @(negedge clk);
        chk(sec_we && sec_addr == 24'h001000 && !sec_mirror, "R9 back-to-back secondary", {8'd0, sec_addr}, 32'h001000);

        // R8: same-edge map load is not seen by that request
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 1'b1; cfg_word = 2'd0; cfg_data = 32'h0;
        wr_req = 1'b1; wr_addr = 24'h000400; wr_data = 8'hE5;
        @(negedge clk);
        cfg_we = 1'b0; wr_req = 1'b0;
        @(negedge clk);
        chk(sec_mirror && sec_addr == 24'hE00400, "R8 old map on same edge", {8'd0, sec_addr}, 32'hE00400);
        run_wr(24'h000400, 1'b1, 1'b0, 8'hF6);
        cfg(1'b0, 2'd3, 32'h8000_0000);
        cfg(1'b1, 2'd3, 32'h8000_0000);
        run_wr(24'hFFFC00, 1'b1, 1'b1, 8'h77);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule